// File: doc/BRIEF.md
# Stallable Block RAM Read Pipeline

This block is a single-clock memory with one write port and one read port. Reads are issued as a stream of addresses under a valid/ready handshake, and the words come out in the same order under a second valid/ready handshake. There is no skid buffer. When the consumer stops accepting, the block stops the pipeline by lowering the memory read enable and, if the extra output stage is present, that stage's clock enable. The word already read then stays in its register until the consumer takes it.

Writes are independent of reads. A write can happen in any cycle without triggering a read. Each read enable is raised only in a cycle that actually moves a word. The parameter `OUT_REG` selects between a one-cycle read path and a two-cycle read path with a registered output. Reset clears only the occupancy flags and leaves the stored words untouched.

Top module: `stall_ram_pipe`

## Requirements
- R1: With `OUT_REG`=0, an address accepted in one cycle (`rd_valid` and `rd_ready` both high) has its word shown on `out_data` with `out_valid` high in the very next cycle.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the following cycle.
- R3: Every accepted address yields exactly one delivered word (`out_valid` and `out_ready` both high). The words are delivered in acceptance order, and each is the memory contents at that address.
- R4: `rd_ready` is high whenever `out_ready` is high, or whenever fewer words are in flight than the pipeline depth (1 + `OUT_REG`). With `out_ready` held high, one address is accepted and one word is delivered every cycle.
- R5: With `OUT_REG`=1, a word reaches the output exactly two cycles after its address is accepted, unless an older word ahead of it is still waiting.
- R6: A write (`wr_en` high) with `rd_valid` low stores the word and produces no output word.
- R7: When an accepted read and a write hit the same address in the same cycle, the read returns the contents from before the write.
- R8: A synchronous active-high `rst` drops `out_valid` to 0 in the next cycle and discards words in flight. Memory contents are kept across reset.
- R9: The memory read enable is raised only in a cycle that accepts an address. When no new word enters the output position, `out_data` keeps its value, even if `rd_addr` changes and even while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Read address offered |
| rd_addr | input | ADDR_W | Read address |
| rd_ready | output | 1 | Read address taken this cycle if offered |
| out_valid | output | 1 | Output word present |
| out_data | output | DATA_W | Output word |
| out_ready | input | 1 | Consumer takes the output word |

## Verification
The bench instantiates the block twice from the same stimulus: once with `OUT_REG`=0 and once with `OUT_REG`=1, both with `DATA_W`=16 and `ADDR_W`=6. The first instance reaches the one-cycle read path and its single-stage stall. The second reaches the case where the registered stage holds a stalled word while the memory register holds the next one, which is the double-stall case. Running both from the same address stream, random backpressure, same-address read/write collisions and a reset with words in flight checks each instance's latency, ready behaviour and hold behaviour against its own depth.

// File: rtl/srp_pkg.sv
package srp_pkg;

    // A pipeline slot may take a new entry when it is empty or its content leaves.
    function automatic logic slot_advance(input logic occupied, input logic downstream_ready);
        return !occupied || downstream_ready;
    endfunction

endpackage

// File: rtl/srp_mem.sv
module srp_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] rd_data_d, rd_data_q;

    // Read register loads only under its enable; otherwise it holds.
    always_comb begin
        rd_data_d = rd_data_q;
        if (rd_en) rd_data_d = cells[rd_addr];
    end

    // Nonblocking update gives read-before-write on an address collision.
    always_ff @(posedge clk) begin
        rd_data_q <= rd_data_d;
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = rd_data_q;
endmodule

// File: rtl/srp_stage_ctl.sv
module srp_stage_ctl
    import srp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fill,
    input  logic down_ready,
    output logic advance,
    output logic occupied
);
    typedef struct packed {
        logic occ;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d   = ctl_q;
        advance = slot_advance(ctl_q.occ, down_ready);
        if (advance) ctl_d.occ = fill;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign occupied = ctl_q.occ;
endmodule

// File: rtl/srp_out_stage.sv
module srp_out_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (en) data_d = d;
    end

    always_ff @(posedge clk) begin
        data_q <= data_d;
    end

    assign q = data_q;
endmodule

// File: rtl/stall_ram_pipe.sv
module stall_ram_pipe #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 6,
    parameter int OUT_REG = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);
    logic              s1_adv;
    logic              s1_occ;
    logic              s1_down_rdy;
    logic              mem_rd_en;
    logic [DATA_W-1:0] mem_rd_data;

    // Read only when an address is actually taken; never during reset.
    assign mem_rd_en = s1_adv && rd_valid && !rst;
    assign rd_ready  = s1_adv;

    srp_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (mem_rd_en),
        .rd_addr (rd_addr),
        .rd_data (mem_rd_data)
    );

    srp_stage_ctl u_s1 (
        .clk        (clk),
        .rst        (rst),
        .fill       (rd_valid),
        .down_ready (s1_down_rdy),
        .advance    (s1_adv),
        .occupied   (s1_occ)
    );

    generate
        if (OUT_REG != 0) begin : g_reg
            logic              s2_adv;
            logic              s2_occ;
            logic              s2_en;
            logic [DATA_W-1:0] s2_data;

            // Second enable: load only when a word moves forward.
            assign s2_en = s2_adv && s1_occ && !rst;

            srp_stage_ctl u_s2 (
                .clk        (clk),
                .rst        (rst),
                .fill       (s1_occ),
                .down_ready (out_ready),
                .advance    (s2_adv),
                .occupied   (s2_occ)
            );

            srp_out_stage #(.DATA_W(DATA_W)) u_s2_data (
                .clk (clk),
                .en  (s2_en),
                .d   (mem_rd_data),
                .q   (s2_data)
            );

            assign s1_down_rdy = s2_adv;
            assign out_valid   = s2_occ;
            assign out_data    = s2_data;
        end else begin : g_direct
            assign s1_down_rdy = out_ready;
            assign out_valid   = s1_occ;
            assign out_data    = mem_rd_data;
        end
    endgenerate
endmodule

// File: rtl/srp_chk.sv
module srp_chk #(
    parameter int DATA_W  = 16,
    parameter int OUT_REG = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic              mem_rd_en,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R9
    rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> rd_valid && rd_ready);

    // R4
    ready_pass_chk: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> rd_ready);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

    generate
        if (OUT_REG == 0) begin : g_lat1
            // R1
            one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
                rd_valid && rd_ready |=> out_valid);
        end
    endgenerate
endmodule

bind stall_ram_pipe srp_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .mem_rd_en (mem_rd_en),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/srp_score.sv
module srp_score #(
    parameter int LAT    = 1,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic              out_valid,
    input  logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output int                checks,
    output int                errors
);
    logic [DATA_W-1:0] ref_mem [1 << ADDR_W];
    logic [DATA_W-1:0] q_data [$];
    int                q_due  [$];
    string             q_tag  [$];
    int                cyc = 0;
    bit                rst_q = 0;
    bit                has_last = 0;
    logic [DATA_W-1:0] last;
    bit                stalled = 0;
    logic [DATA_W-1:0] stall_data;
    int                post_rst = 0;
    string             lat_tag;

    initial begin
        checks  = 0;
        errors  = 0;
        lat_tag = (LAT == 1) ? "R1" : "R5";
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (depth %0d) cycle %0d actual %h expected %h", tag, LAT, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        rst_q <= rst;
    end

    always @(negedge clk) begin
        if (rst) begin
            if (q_data.size() > 0 && q_due[0] <= cyc) begin
                last     = q_data[0];
                has_last = 1;
            end
            if (rst_q) chk(out_valid === 1'b0, "R8", 32'(out_valid), 0);
            q_data.delete();
            q_due.delete();
            q_tag.delete();
            stalled  = 0;
            post_rst = 4;
        end else begin
            bit vis;
            bit exp_rdy;
            vis = q_data.size() > 0 && q_due[0] <= cyc;
            chk(out_valid === vis, lat_tag, 32'(out_valid), 32'(vis));
            if (vis) begin
                last     = q_data[0];
                has_last = 1;
                chk(out_data === q_data[0], q_tag[0], 32'(out_data), 32'(q_data[0]));
            end else if (has_last) begin
                chk(out_data === last, "R9", 32'(out_data), 32'(last));
            end
            if (stalled)
                chk(out_valid === 1'b1 && out_data === stall_data, "R2", 32'(out_data), 32'(stall_data));
            stalled    = out_valid && !out_ready;
            stall_data = out_data;
            exp_rdy = (q_data.size() < LAT) || out_ready;
            chk(rd_ready === exp_rdy, "R4", 32'(rd_ready), 32'(exp_rdy));
            if (vis && out_ready) begin
                void'(q_data.pop_front());
                void'(q_due.pop_front());
                void'(q_tag.pop_front());
            end
            if (rd_valid && rd_ready) begin
                q_data.push_back(ref_mem[rd_addr]);
                q_due.push_back(cyc + LAT);
                if (wr_en && wr_addr == rd_addr) q_tag.push_back("R7");
                else if (post_rst > 0)           q_tag.push_back("R8");
                else                             q_tag.push_back("R3");
                if (post_rst > 0) post_rst--;
            end
            if (wr_en) ref_mem[wr_addr] = wr_data;
        end
    end
endmodule

// File: tb/stall_ram_pipe_test.sv
module stall_ram_pipe_test;
    localparam int DW = 16;
    localparam int AW = 6;

    logic          clk = 0;
    logic          rst = 1;
    logic          wr_en = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_valid = 0;
    logic [AW-1:0] rd_addr = '0;
    logic          out_ready = 0;
    logic          rdy0, rdy1, ov0, ov1;
    logic [DW-1:0] od0, od1;
    int            c0, e0, c1, e1;
    int            tb_checks = 0;
    int            tb_errors = 0;

    always #10 clk = ~clk;

    stall_ram_pipe #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(0)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rdy0),
        .out_valid(ov0), .out_data(od0), .out_ready(out_ready)
    );

    stall_ram_pipe #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(1)) uut_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rdy1),
        .out_valid(ov1), .out_data(od1), .out_ready(out_ready)
    );

    srp_score #(.LAT(1), .DATA_W(DW), .ADDR_W(AW)) sb0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rdy0),
        .out_valid(ov0), .out_data(od0), .out_ready(out_ready), .checks(c0), .errors(e0)
    );

    srp_score #(.LAT(2), .DATA_W(DW), .ADDR_W(AW)) sb1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rdy1),
        .out_valid(ov1), .out_data(od1), .out_ready(out_ready), .checks(c1), .errors(e1)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic tchk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tb_checks++;
        if (!ok) begin
            tb_errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_all();
        // Reset state
        repeat (3) step();
        #5;
        tchk(ov0 === 1'b0 && ov1 === 1'b0, "R8", {ov1, ov0}, 0);
        rst = 0;
        step();

        // R6: write-only fill, no output words appear
        for (int a = 0; a < (1 << AW); a++) begin
            wr_en   = 1;
            wr_addr = AW'(a);
            wr_data = DW'(a * 911 + 17);
            out_ready = a[0];
            step();
            #5;
            tchk(ov0 === 1'b0 && ov1 === 1'b0, "R6", {ov1, ov0}, 0);
        end
        wr_en = 0;

        // R4: continuous ready gives one address per cycle
        out_ready = 1;
        for (int i = 0; i < 40; i++) begin
            rd_valid = 1;
            rd_addr  = AW'(i * 5);
            #5;
            tchk(rdy0 === 1'b1 && rdy1 === 1'b1, "R4", {rdy1, rdy0}, 2'b11);
            step();
        end
        rd_valid = 0;
        repeat (3) step();

        // Random traffic with writes and backpressure (R2, R3)
        for (int i = 0; i < 400; i++) begin
            rd_valid  = ($urandom % 4) != 0;
            rd_addr   = AW'($urandom);
            wr_en     = ($urandom % 3) == 0;
            wr_addr   = AW'($urandom);
            wr_data   = DW'($urandom);
            out_ready = ($urandom % 3) != 0;
            step();
        end
        wr_en = 0;

        // R7: same-address read and write
        out_ready = 1;
        for (int i = 0; i < 8; i++) begin
            rd_valid = 1;
            rd_addr  = AW'(i + 3);
            wr_en    = 1;
            wr_addr  = AW'(i + 3);
            wr_data  = DW'(16'hA500 + i);
            step();
        end
        wr_en = 0;

        // R2/R9: stall with changing addresses, then idle with changing addresses
        out_ready = 0;
        for (int i = 0; i < 5; i++) begin
            rd_valid = 1;
            rd_addr  = AW'(i * 7 + 1);
            step();
        end
        rd_valid = 0;
        for (int i = 0; i < 4; i++) begin
            rd_addr = AW'(i * 11);
            step();
        end
        out_ready = 1;
        repeat (4) step();
        for (int i = 0; i < 4; i++) begin
            rd_addr = AW'(i * 13 + 2);
            step();
        end

        // R8: reset with words in flight, then read back stored data
        out_ready = 0;
        rd_valid  = 1;
        for (int i = 0; i < 3; i++) begin
            rd_addr = AW'(i + 20);
            step();
        end
        rd_valid = 0;
        rst      = 1;
        repeat (2) step();
        rst = 0;
        out_ready = 1;
        for (int i = 0; i < 8; i++) begin
            rd_valid = 1;
            rd_addr  = AW'(i + 40);
            step();
        end
        rd_valid = 0;
        repeat (6) step();
    endtask

    initial begin
        bit timeout = 0;
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) begin
            tb_checks++;
            tb_errors++;
            $display("FAIL watchdog expired");
        end
        $display("CHECKS %0d ERRORS %0d", tb_checks + c0 + c1, tb_errors + e0 + e1);
        $finish;
    end
endmodule